// File: doc/BRIEF.md
# Fibonacci Link Codeword Checker and Decoder

This block sits at the receiving end of a network-on-chip link that carries 48-bit crosstalk-safe codewords. Each codeword holds 46 Fibonacci-weighted code bits, then a repeat of the highest code bit, then a parity bit in the top position. The block recomputes parity over the lower 47 bits and raises an error flag when it disagrees with the top bit, so the router can ask for the word again. When parity agrees, the 32-bit binary word is rebuilt as the Fibonacci-weighted sum of the code bits.

The received codeword is also forwarded unchanged beside the decoded data. A router that encodes once at the source and checks at every hop can therefore pass the codeword on without encoding it again. Handling of retransmission, buffering and routing belongs to the surrounding router.

Both sides of the block are valid/ready streams, and one output register sits between them. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new word is taken.

Top module: `fib_link_decoder`

## Requirements
- R1: Bit index i of `in_code` (i = 0..45) is code bit d(i+1) and carries the weight f(i+1), where f(1)=1, f(2)=1 and f(m)=f(m-1)+f(m-2). For a word with no parity error, `out_data` equals the sum of those weights over the set bits, taken modulo 2^32.
- R2: `out_err` is 1 exactly when the XOR of `in_code` bits 46..0 differs from bit 47 of the accepted word.
- R3: Flipping any single one of the 48 bits of a correctly formed codeword always sets `out_err`.
- R4: `out_code` equals the accepted `in_code` bit for bit, whether or not there is an error.
- R5: A word accepted on a rising edge appears on the outputs, with `out_valid` high, right after that same edge (one cycle of latency).
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_code` and `out_err` keep their values across the edge.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: An active-low reset (`rst_n` = 0) clears `out_valid` and `out_err` at once.
- R9: `out_err` is never high while `out_valid` is low.
- R10: On an edge where `in_ready` is high and `in_valid` is low, `out_valid` goes low.
- R11: The all-zero codeword decodes to 0, and the codeword of 0xFFFFFFFF decodes back exactly to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A codeword is offered |
| in_ready | output | 1 | The block can take a codeword this cycle |
| in_code | input | 48 | Received codeword, bit 0 = d1, bit 47 = parity |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Decoded binary word (don't-care when `out_err` is set) |
| out_code | output | 48 | Accepted codeword, unmodified |
| out_err | output | 1 | Parity mismatch on the held word |

## Verification
The bench builds the block with its default parameters: 46 code bits and 32 data bits, which gives a 48-bit codeword and a 64-leaf adder tree. This puts the largest weights, f(45) and f(46), within reach, together with the top code bit and its copy. Those bits are driven both by words near 2^32 that its own encoder produces and by single-bit corruptions of every one of the 48 positions. Holding `out_ready` low exercises the stall and hold path of the output register.

// File: rtl/fibdec_pkg.sv
package fibdec_pkg;

  // Fibonacci number f(k) with f(0)=0, f(1)=1; used only at elaboration.
  function automatic logic [63:0] fib_val(input int k);
    logic [63:0] a, b, t;
    a = 64'd0;
    b = 64'd1;
    for (int i = 0; i < k; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

endpackage

// File: rtl/fib_parity_check.sv
module fib_parity_check #(
  parameter int CODE_W = 48
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              bad_o
);
  logic recomputed;

  always_comb begin
    recomputed = ^code_i[CODE_W-2:0];
    bad_o      = recomputed ^ code_i[CODE_W-1];
  end
endmodule

// File: rtl/fib_weight_sum.sv
module fib_weight_sum #(
  parameter int FIB_BITS = 46,
  parameter int DATA_W   = 32
) (
  input  logic [FIB_BITS-1:0] code_i,
  output logic [DATA_W-1:0]   sum_o
);
  localparam int LEVELS = $clog2(FIB_BITS);
  localparam int LEAVES = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int N = LEAVES >> l;
    logic [DATA_W-1:0] s [N];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < N; j++) begin : g_term
        if (j < FIB_BITS) begin : g_used
          localparam logic [DATA_W-1:0] WEIGHT = DATA_W'(fibdec_pkg::fib_val(j + 1));
          assign s[j] = code_i[j] ? WEIGHT : '0;
        end else begin : g_pad
          assign s[j] = '0;
        end
      end
    end else begin : g_add
      for (genvar j = 0; j < N; j++) begin : g_node
        assign s[j] = g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].s[0];
endmodule

// File: rtl/fib_out_stage.sv
module fib_out_stage #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bad_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CODE_W-1:0] out_code,
  output logic              out_err
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
      out_code  <= '0;
    end else if (load) begin
      out_valid <= in_valid;
      out_err   <= in_valid & bad_i;
      if (in_valid) begin
        out_data <= data_i;
        out_code <= code_i;
      end
    end
  end

  // R5: accepted word is presented after one edge
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4: codeword forwarded unchanged
  assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_code == $past(code_i)));

  // R6: stalled outputs hold
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) &&
                                   $stable(out_data) && $stable(out_err)));

  // R9: error flag only with a valid result
  assert_err_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  // R10: idle slot empties the register
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/fib_link_decoder.sv
module fib_link_decoder #(
  parameter int FIB_BITS = 46,
  parameter int DATA_W   = 32,
  localparam int CODE_W  = FIB_BITS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CODE_W-1:0] out_code,
  output logic              out_err
);
  logic              parity_bad;
  logic [DATA_W-1:0] weighted;

  fib_parity_check #(.CODE_W(CODE_W)) i_parity (
    .code_i (in_code),
    .bad_o  (parity_bad)
  );

  fib_weight_sum #(.FIB_BITS(FIB_BITS), .DATA_W(DATA_W)) i_sum (
    .code_i (in_code[FIB_BITS-1:0]),
    .sum_o  (weighted)
  );

  fib_out_stage #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .data_i    (weighted),
    .code_i    (in_code),
    .bad_i     (parity_bad),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_code  (out_code),
    .out_err   (out_err)
  );

  // R2: registered flag matches parity of the accepted word
  assert_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_err == ((^$past(in_code[CODE_W-2:0])) != $past(in_code[CODE_W-1]))));
endmodule

// File: tb/test_fib_link_decoder.sv
`timescale 1ns/1ps
module test_fib_link_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [47:0] in_code;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [47:0] out_code;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fib_link_decoder i_fib_link_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_code(out_code), .out_err(out_err)
  );

  function automatic longint unsigned fib(input int k);
    longint unsigned a = 0, b = 1, t;
    for (int i = 0; i < k; i++) begin
      t = a + b; a = b; b = t;
    end
    return a;
  endfunction

  // Behavioural encoder: 46 code bits, copy of top bit, parity on top.
  function automatic logic [47:0] enc(input logic [31:0] v);
    logic [45:0] d = '0;
    longint unsigned r;
    logic par;
    if (64'(v) >= fib(47)) begin d[45] = 1'b1; r = 64'(v) - fib(46); end
    else r = 64'(v);
    for (int k = 45; k >= 2; k--) begin
      if (r >= fib(k+1)) d[k-1] = 1'b1;
      else if (r < fib(k)) d[k-1] = 1'b0;
      else d[k-1] = d[k];
      if (d[k-1]) r = r - fib(k);
    end
    d[0] = r[0];
    par = (^d) ^ d[45];
    return {par, d[45], d};
  endfunction

  function automatic logic par_bad(input logic [47:0] c);
    return (^c[46:0]) != c[47];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Offer one word with out_ready high; check after the accepting edge.
  task automatic xfer(input logic [47:0] c, input logic [31:0] exp_data,
                      input bit check_data, input string req);
    logic e = par_bad(c);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R5", "valid after one edge", out_valid, 1);
    chk(out_err == e, "R2", "parity flag", out_err, e);
    chk(out_code == c, "R4", "passthrough", out_code, c);
    if (check_data && !e) chk(out_data == exp_data, req, "decoded data", out_data, exp_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [47:0] c, a_code, b_code;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "valid in reset", out_valid, 0);
    chk(out_err == 1'b0, "R8", "err in reset", out_err, 0);
    rst_n = 1'b1;
    #1 chk(in_ready == 1'b1, "R7", "ready when empty", in_ready, 1);

    // R11 corners, R1 directed
    xfer(48'd0, 32'd0, 1, "R11");
    xfer(enc(32'hFFFF_FFFF), 32'hFFFF_FFFF, 1, "R11");
    xfer(enc(32'd1), 32'd1, 1, "R1");
    xfer(enc(32'd2), 32'd2, 1, "R1");
    xfer(enc(32'h8000_0000), 32'h8000_0000, 1, "R1");
    xfer(enc(32'd2971215073), 32'd2971215073, 1, "R1");

    // R1 random recovery
    for (int n = 0; n < 300; n++) begin
      v = $urandom;
      xfer(enc(v), v, 1, "R1");
    end

    // R3 every single-bit flip flags an error
    for (int n = 0; n < 12; n++) begin
      c = enc($urandom);
      for (int b = 0; b < 48; b++) begin
        xfer(c ^ (48'd1 << b), 32'd0, 0, "R3");
        chk(out_err == 1'b1, "R3", "flip flagged", out_err, 1);
      end
    end

    // R2 arbitrary vectors
    for (int n = 0; n < 100; n++) begin
      c = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      xfer(c, 32'd0, 0, "R2");
    end

    // R10 idle slot empties register
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "valid after idle", out_valid, 0);
    chk(out_err == 1'b0, "R9", "err without valid", out_err, 0);

    // R6/R7 back-pressure
    a_code = enc(32'h1234_5678) ^ 48'h1; // erroneous word held during stall
    b_code = enc(32'hCAFE_F00D);
    @(negedge clk); in_valid = 1'b1; in_code = a_code; out_ready = 1'b0;
    @(negedge clk); in_code = b_code;
    #1 chk(in_ready == 1'b0, "R7", "ready during stall", in_ready, 0);
    @(negedge clk);
    chk(out_code == a_code, "R6", "code held", out_code, a_code);
    chk(out_err == 1'b1, "R6", "err held", out_err, 1);
    chk(out_valid == 1'b1, "R6", "valid held", out_valid, 1);
    out_ready = 1'b1;
    #1 chk(in_ready == 1'b1, "R7", "ready when drained", in_ready, 1);
    @(negedge clk); in_valid = 1'b0;
    chk(out_code == b_code, "R6", "next word after stall", out_code, b_code);
    chk(out_data == 32'hCAFE_F00D, "R1", "data after stall", out_data, 32'hCAFE_F00D);
    chk(out_err == 1'b0, "R2", "clean word after stall", out_err, 0);

    // R8 reset while holding an erroneous word
    @(negedge clk); in_valid = 1'b1; in_code = a_code; out_ready = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    rst_n = 1'b0;
    #1 chk(out_valid == 1'b0, "R8", "valid cleared", out_valid, 0);
    chk(out_err == 1'b0, "R8", "err cleared", out_err, 0);
    @(negedge clk); rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule